// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block orders the calibration steps of a successive-approximation converter. A start request, qualified by a 3-bit calibration-type code, launches a sequence drawn from three phases (internal DAC trim, gain trim and offset trim). The phases always run in that order and never overlap, and each code picks a fixed subset of them. The top bit of the code chooses between self calibration and system calibration. That choice is shown on a separate output for the whole sequence, so the analog side knows which reference the gain and offset steps use.

Each phase is a timed state with a fixed length in master-clock cycles, set by a parameter. The default lengths add up to 125013 cycles for the full self sequence, 111124 cycles for DAC plus gain, and 13889 cycles for offset. A busy flag and a start bit rise together one cycle after an accepted request. Both clear in the cycle after the final phase ends. While the sequencer is idle, a 2-bit selector is decoded into a one-hot enable for one of four calibration coefficient registers. While a sequence runs, that decode is held off.

Top module: `calseq_ctrl`

## Requirements
- R1: After reset, busy, start_bit, phase_oh, phase_done and seq_done are all 0.
- R2: A start_req sampled while busy is 0 makes busy and start_bit read 1 from the next clock edge onward.
- R3: cal_code[2] selects system (1) or self (0) calibration and is shown on phase_sys for the whole sequence. cal_code[1:0] selects the phases: 00 = DAC, gain, offset; 01 = gain, offset; 10 = offset only; 11 = gain only.
- R4: phase_oh is one-hot while busy (bit 0 DAC, bit 1 gain, bit 2 offset) and 0 while idle. The selected phases appear strictly in the order DAC, gain, offset.
- R5: Each phase holds phase_oh for exactly DAC_CYC, GAIN_CYC or OFFS_CYC cycles.
- R6: phase_done is high on the last cycle of every phase. seq_done is high only on the last cycle of the last phase.
- R7: busy and start_bit fall together in the cycle after the last phase. busy stays high for exactly the sum of the selected phase lengths.
- R8: A start_req that arrives while busy is ignored: the phase order, phase lengths and phase_sys of the running sequence do not change.
- R9: While busy is 0, coef_en is one-hot with bit coef_sel set. While busy is 1, coef_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start-calibration request, one cycle |
| cal_code | input | 3 | Calibration type: system/self bit, phase subset |
| coef_sel | input | 2 | Coefficient register selector |
| busy | output | 1 | Sequence in progress |
| start_bit | output | 1 | Start-calibration bit, cleared at sequence end |
| phase_oh | output | 3 | One-hot active phase (DAC, gain, offset) |
| phase_sys | output | 1 | Running sequence is a system calibration |
| phase_done | output | 1 | Last cycle of the current phase |
| seq_done | output | 1 | Last cycle of the whole sequence |
| coef_en | output | 4 | One-hot coefficient register enable |

## Verification
The assertions check, on every cycle, the invariants that hold regardless of code: phase_oh stays one-hot and tracks busy, the phase moves only on a done strobe and never steps backward, busy and start_bit move as one, and the coefficient decode is gated. They also check that a request while busy leaves phase_sys unchanged. Only the bench scenarios can show that each code yields its exact phase list, that every phase lasts its exact cycle count, and that a request injected mid-sequence leaves the total length unchanged. Those checks need the code-to-subset mapping and the parameter values, which the properties do not know.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

   localparam int NUM_PHASES = 3;

   typedef enum logic [1:0] {
      PH_DAC  = 2'd0,
      PH_GAIN = 2'd1,
      PH_OFFS = 2'd2,
      PH_NONE = 2'd3
   } phase_e;

   // Phase subset chosen by the low two bits of the calibration code.
   function automatic logic [NUM_PHASES-1:0] subset_of(input logic [1:0] sel);
      logic [NUM_PHASES-1:0] m;
      case (sel)
         2'b00:   m = 3'b111;
         2'b01:   m = 3'b110;
         2'b10:   m = 3'b100;
         default: m = 3'b010;
      endcase
      return m;
   endfunction

   // First phase in the mask that comes after cur (PH_NONE means "from the start").
   function automatic phase_e step_after(input logic [NUM_PHASES-1:0] mask,
                                         input phase_e cur);
      phase_e res;
      res = PH_NONE;
      for (int k = NUM_PHASES - 1; k >= 0; k--) begin
         if (mask[k] && (cur == PH_NONE || k > int'(cur)))
            res = phase_e'(k);
      end
      return res;
   endfunction

endpackage

// File: rtl/calseq_plan.sv
module calseq_plan
   import calseq_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic [CODE_W-1:0]     code,
   output logic [NUM_PHASES-1:0] mask,
   output logic                  sys
);
   generate
      if (CODE_W != 3) begin : g_bad_code
         $error("calseq_plan: CODE_W must be 3");
      end
   endgenerate

   always_comb begin
      mask = subset_of(code[1:0]);
      sys  = code[CODE_W-1];
   end
endmodule

// File: rtl/calseq_timer.sv
module calseq_timer
   import calseq_pkg::*;
#(
   parameter int DAC_CYC  = 83343,
   parameter int GAIN_CYC = 27781,
   parameter int OFFS_CYC = 13889,
   parameter int CNT_W    = 17
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  phase_e load_phase,
   output logic   last
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_m1;

   always_comb begin
      case (load_phase)
         PH_DAC:  len_m1 = CNT_W'(DAC_CYC - 1);
         PH_GAIN: len_m1 = CNT_W'(GAIN_CYC - 1);
         PH_OFFS: len_m1 = CNT_W'(OFFS_CYC - 1);
         default: len_m1 = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= len_m1;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/calseq_coef_dec.sv
module calseq_coef_dec #(
   parameter int SEL_W = 2,
   localparam int N_REG = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             enable,
   output logic [N_REG-1:0] onehot
);
   generate
      for (genvar i = 0; i < N_REG; i++) begin : g_line
         assign onehot[i] = enable && (sel == SEL_W'(i));
      end
   endgenerate
endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
   import calseq_pkg::*;
#(
   parameter int DAC_CYC  = 83343,
   parameter int GAIN_CYC = 27781,
   parameter int OFFS_CYC = 13889,
   parameter int SEL_W    = 2,
   localparam int MAX_A   = (DAC_CYC > GAIN_CYC) ? DAC_CYC : GAIN_CYC,
   localparam int MAX_CYC = (MAX_A > OFFS_CYC) ? MAX_A : OFFS_CYC,
   localparam int CNT_W   = $clog2(MAX_CYC + 1),
   localparam int N_REG   = 1 << SEL_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_req,
   input  logic [2:0]            cal_code,
   input  logic [SEL_W-1:0]      coef_sel,
   output logic                  busy,
   output logic                  start_bit,
   output logic [NUM_PHASES-1:0] phase_oh,
   output logic                  phase_sys,
   output logic                  phase_done,
   output logic                  seq_done,
   output logic [N_REG-1:0]      coef_en
);
   generate
      if (DAC_CYC < 1 || GAIN_CYC < 1 || OFFS_CYC < 1) begin : g_bad_len
         $error("calseq_ctrl: every phase length must be at least one cycle");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("calseq_ctrl: SEL_W must be positive");
      end
   endgenerate

   logic [NUM_PHASES-1:0] req_mask, mask_q;
   logic                  req_sys, sys_q;
   phase_e                cur_q, first_ph, next_ph, load_ph;
   logic                  busy_q, stbit_q;
   logic                  accept, ph_end, tmr_last, tmr_load;

   calseq_plan #(.CODE_W(3)) u_plan (
      .code (cal_code),
      .mask (req_mask),
      .sys  (req_sys)
   );

   assign accept   = start_req && !busy_q;
   assign first_ph = step_after(req_mask, PH_NONE);
   assign next_ph  = step_after(mask_q, cur_q);
   assign ph_end   = busy_q && tmr_last;
   assign tmr_load = accept || (ph_end && next_ph != PH_NONE);
   assign load_ph  = accept ? first_ph : next_ph;

   calseq_timer #(
      .DAC_CYC  (DAC_CYC),
      .GAIN_CYC (GAIN_CYC),
      .OFFS_CYC (OFFS_CYC),
      .CNT_W    (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (tmr_load),
      .load_phase (load_ph),
      .last       (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= PH_NONE;
         mask_q  <= '0;
         sys_q   <= 1'b0;
         busy_q  <= 1'b0;
         stbit_q <= 1'b0;
      end else if (accept) begin
         cur_q   <= first_ph;
         mask_q  <= req_mask;
         sys_q   <= req_sys;
         busy_q  <= 1'b1;
         stbit_q <= 1'b1;
      end else if (ph_end) begin
         cur_q <= next_ph;
         if (next_ph == PH_NONE) begin
            busy_q  <= 1'b0;
            stbit_q <= 1'b0;
            sys_q   <= 1'b0;
         end
      end
   end

   generate
      for (genvar p = 0; p < NUM_PHASES; p++) begin : g_ph
         assign phase_oh[p] = busy_q && (cur_q == phase_e'(p));
      end
   endgenerate

   calseq_coef_dec #(.SEL_W(SEL_W)) u_coef (
      .sel    (coef_sel),
      .enable (!busy_q),
      .onehot (coef_en)
   );

   assign busy       = busy_q;
   assign start_bit  = stbit_q;
   assign phase_sys  = sys_q;
   assign phase_done = ph_end;
   assign seq_done   = ph_end && (next_ph == PH_NONE);
endmodule

// File: rtl/calseq_ctrl_chk.sv
module calseq_ctrl_chk
   import calseq_pkg::*;
#(
   parameter int SEL_W = 2,
   localparam int N_REG = 1 << SEL_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_req,
   input logic [2:0]            cal_code,
   input logic [SEL_W-1:0]      coef_sel,
   input logic                  busy,
   input logic                  start_bit,
   input logic [NUM_PHASES-1:0] phase_oh,
   input logic                  phase_sys,
   input logic                  phase_done,
   input logic                  seq_done,
   input logic [N_REG-1:0]      coef_en
);
   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy) |=> (busy && start_bit)); // R2

   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_oh) && (busy == (phase_oh != '0))); // R4

   AST_NO_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase_oh[2]) |=> (phase_oh[2] || !busy)); // R4

   AST_DAC_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_oh[0]) |-> !$past(busy)); // R4

   AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !phase_done) |=> $stable(phase_oh)); // R5

   AST_DONE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      phase_done |=> (phase_oh != $past(phase_oh))); // R6

   AST_SEQ_DONE_IS_PHASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> phase_done); // R6

   AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> (!busy && !start_bit)); // R7

   AST_BUSY_MATCHES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy == start_bit); // R7

   AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_req && !seq_done) |=> $stable(phase_sys)); // R8

   AST_COEF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (coef_en == '0)); // R9

   AST_COEF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ($onehot(coef_en) && coef_en[coef_sel])); // R9
endmodule

bind calseq_ctrl calseq_ctrl_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/calseq_ctrl_tb.sv
module calseq_ctrl_tb;
   localparam int DAC_N  = 6;
   localparam int GAIN_N = 4;
   localparam int OFFS_N = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_req = 1'b0;
   logic [2:0] cal_code = 3'b000;
   logic [1:0] coef_sel = 2'b00;
   logic       busy, start_bit, phase_sys, phase_done, seq_done;
   logic [2:0] phase_oh;
   logic [3:0] coef_en;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   calseq_ctrl #(.DAC_CYC(DAC_N), .GAIN_CYC(GAIN_N), .OFFS_CYC(OFFS_N)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .cal_code(cal_code),
      .coef_sel(coef_sel), .busy(busy), .start_bit(start_bit), .phase_oh(phase_oh),
      .phase_sys(phase_sys), .phase_done(phase_done), .seq_done(seq_done),
      .coef_en(coef_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected phase history (3 bits per phase, oldest in the high slot) from R3/R4.
   function automatic logic [11:0] exp_hist(input logic [1:0] sel);
      case (sel)
         2'b00:   return {3'b000, 3'b001, 3'b010, 3'b100};
         2'b01:   return {6'b0, 3'b010, 3'b100};
         2'b10:   return {9'b0, 3'b100};
         default: return {9'b0, 3'b010};
      endcase
   endfunction

   task automatic run_code(input logic [2:0] code, input int inject_at, input string tag);
      logic [11:0] hist = '0;
      logic [2:0]  prev = '0;
      int total = 0, n_done = 0, sys_bad = 0, coef_bad = 0, seqd_at = -1;
      int len_dac = 0, len_gain = 0, len_offs = 0;
      int e_dac, e_gain, e_offs, e_done;
      @(negedge clk);
      cal_code  = code;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      check(busy && start_bit, {tag, " R2 busy after start"}, int'(busy), 1);
      while (busy && total < 500) begin
         if (phase_oh != prev) begin
            hist = {hist[8:0], phase_oh};
            prev = phase_oh;
         end
         if (phase_oh == 3'b001) len_dac++;
         if (phase_oh == 3'b010) len_gain++;
         if (phase_oh == 3'b100) len_offs++;
         if (phase_done) n_done++;
         if (seq_done) seqd_at = total;
         if (phase_sys != code[2]) sys_bad++;
         if (coef_en != 4'b0) coef_bad++;
         total++;
         if (total == inject_at) begin
            cal_code  = ~code;
            start_req = 1'b1;
         end else begin
            start_req = 1'b0;
         end
         @(negedge clk);
      end
      start_req = 1'b0;
      e_dac  = (code[1:0] == 2'b00) ? DAC_N : 0;
      e_gain = (code[1:0] != 2'b10) ? GAIN_N : 0;
      e_offs = (code[1:0] == 2'b11) ? 0 : OFFS_N;
      e_done = (e_dac != 0) + (e_gain != 0) + (e_offs != 0);
      check(hist == exp_hist(code[1:0]), {tag, " R4 phase order"}, int'(hist), int'(exp_hist(code[1:0])));
      check(len_dac == e_dac && len_gain == e_gain && len_offs == e_offs,
            {tag, " R5 phase lengths"}, len_dac*100 + len_gain*10 + len_offs,
            e_dac*100 + e_gain*10 + e_offs);
      check(n_done == e_done, {tag, " R6 phase_done count"}, n_done, e_done);
      check(seqd_at == e_dac + e_gain + e_offs - 1, {tag, " R6 seq_done on last cycle"},
            seqd_at, e_dac + e_gain + e_offs - 1);
      check(total == e_dac + e_gain + e_offs, {tag, " R7 busy length"}, total, e_dac + e_gain + e_offs);
      check(!busy && !start_bit, {tag, " R7 start_bit cleared"}, int'(start_bit), 0);
      check(sys_bad == 0, {tag, " R3 phase_sys"}, sys_bad, 0);
      check(coef_bad == 0, {tag, " R9 coef_en gated while busy"}, coef_bad, 0);
   endtask

   task automatic test_reset();
      @(negedge clk);
      check(!busy && !start_bit && phase_oh == 3'b0 && !phase_done && !seq_done,
            "R1 reset state", int'({busy, start_bit, phase_oh, phase_done, seq_done}), 0);
   endtask

   task automatic test_coef_idle();
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         coef_sel = 2'(s);
         @(negedge clk);
         check(coef_en == 4'(1 << s), "R9 coef decode idle", int'(coef_en), 1 << s);
      end
   endtask

   task automatic test_ignore();
      // Second request lands mid-sequence with a different code; R8 says nothing changes.
      run_code(3'b000, 3, "R8 ignore");
      run_code(3'b101, 2, "R8 ignore sys");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_reset();
      for (int c = 0; c < 8; c++) run_code(3'(c), -1, $sformatf("code%0d", c));
      test_ignore();
      test_coef_idle();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule